// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a free-running 16-bit up-counter watched over by an 8-bit control byte. The byte can only be changed by a 16-bit write whose upper byte carries a fixed key. In watchdog mode, software must restart the counter before it reaches the chosen interval. If it does not, the block asserts a one-cycle system reset request, returns its control byte and counter to zero, and sets a cause flag. A write with a wrong key has the same effect.

In interval-timer mode the counter never resets the system. Each time the interval elapses, the block sets the flag and raises an interrupt request, and the counter keeps running, so the interrupts are periodic.

The counter advances on one of two tick enables, chosen by a control bit. An interval is 2^N ticks, where N is selected from four values. Two control bits for an external reset/NMI pin are only stored and read back. The flag is cleared only by the power-on reset or by an acknowledge in interval-timer mode, so software can tell after a system reset whether this block caused it.

Top module: `wdt_interval_timer`

## Requirements
- R1: After power-on reset (`por_n` low), `rd_data` reads 16'h6900, `sys_rst`, `flag` and `irq` are 0, and the block is in watchdog mode on the fast tick with the 2^15 interval.
- R2: A write (`wr_en` high) whose `wr_data[15:8]` is 8'h5A stores `wr_data[7:0]` as the control byte. Reads always return 8'h69 in `rd_data[15:8]` and the control byte in `rd_data[7:0]`, with bit 3 always reading 0.
- R3: A write with any other upper byte leaves the stored byte unused. At the next edge it clears the control byte and the counter and sets `flag`. `sys_rst` is then high for exactly that one following cycle.
- R4: Control bits [1:0] select the interval as a count of ticks from a counter value of zero to expiry: 00 gives 2^15, 01 gives 2^13, 10 gives 2^9 and 11 gives 2^6. Expiry is the tick that carries into the selected counter bit.
- R5: Control bit 2 selects the tick enable: 0 uses `fast_tick` and 1 uses `slow_tick`. The unselected tick has no effect on the count.
- R6: A keyed write with bit 3 set restarts the counter at zero. A keyed write without bit 3 leaves the counter value unchanged, and no tick is counted in a write cycle.
- R7: While control bit 7 (hold) is 1, the counter keeps its value regardless of ticks. When hold is cleared, counting resumes from that value.
- R8: With control bit 4 at 0 (watchdog mode), expiry clears the control byte and counter and sets `flag`. `sys_rst` is high for the single cycle that follows the expiring tick.
- R9: With control bit 4 at 1 (interval mode), expiry sets `flag` without `sys_rst`. The counter keeps running, so `flag` is set again every interval.
- R10: `irq` is high exactly when `flag`, interval mode, `irq_en` and `gie` are all high.
- R11: `irq_ack` clears `flag` only in interval mode. An expiry in the same cycle wins over the acknowledge, and in watchdog mode the acknowledge is ignored.
- R12: Control bits 5 and 6 are stored and read back but change no other behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; also clears the flag |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Write data: key in [15:8], control byte in [7:0] |
| fast_tick | input | 1 | Fast system tick enable |
| slow_tick | input | 1 | Slow auxiliary tick enable |
| irq_en | input | 1 | Interval interrupt enable |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| rd_data | output | 16 | Read key in [15:8] and control byte in [7:0] |
| sys_rst | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval interrupt request |
| flag | output | 1 | Expiry / reset-cause flag |

## Verification
The hardest cases to reach are the coincidences: an acknowledge arriving on the very tick that expires, and a keyed write landing mid-interval with or without the restart bit. Both depend on the counter's hidden value. The stimulus reaches them by starting from a cleared counter and applying a counted run of ticks, so the bench knows the count without reading it. The full 2^15 watchdog expiry straight out of reset is also run to its end, which shows that the reset state is itself a live watchdog.

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
  parameter int         CW     = 16,
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69,
  parameter int         TAP0   = 15,
  parameter int         TAP1   = 13,
  parameter int         TAP2   = 9,
  parameter int         TAP3   = 6
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        fast_tick,
  input  logic        slow_tick,
  input  logic        irq_en,
  input  logic        gie,
  input  logic        irq_ack,
  output logic [15:0] rd_data,
  output logic        sys_rst,
  output logic        irq,
  output logic        flag
);

  localparam int B_SRC  = 2;
  localparam int B_CLR  = 3;
  localparam int B_MODE = 4;
  localparam int B_HOLD = 7;
  localparam logic [7:0] CLR_MASK = 8'(1 << B_CLR);

  logic [7:0]    ctrl;
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;
  logic          flag_q, rst_q;

  wire key_ok = (wr_data[15:8] == WR_KEY);
  wire wr_ok  = wr_en & key_ok;
  wire wr_bad = wr_en & ~key_ok;
  wire mode_iv = ctrl[B_MODE];
  wire tick = ~ctrl[B_HOLD] & ~wr_en & (ctrl[B_SRC] ? slow_tick : fast_tick);

  always_comb begin
    case (ctrl[1:0])
      2'b00:   mask = (CW'(1) << TAP0) - CW'(1);
      2'b01:   mask = (CW'(1) << TAP1) - CW'(1);
      2'b10:   mask = (CW'(1) << TAP2) - CW'(1);
      default: mask = (CW'(1) << TAP3) - CW'(1);
    endcase
  end

  wire expire    = tick & ((cnt & mask) == mask);
  wire wd_fire   = expire & ~mode_iv;
  wire iv_fire   = expire & mode_iv;
  wire sys_event = wr_bad | wd_fire;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl  <= '0;
      cnt   <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= sys_event;
      if (sys_event) begin
        ctrl <= '0;
        cnt  <= '0;
      end else if (wr_ok) begin
        ctrl <= wr_data[7:0] & ~CLR_MASK;
        if (wr_data[B_CLR]) cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     flag_q <= 1'b0;
    else if (sys_event | iv_fire)   flag_q <= 1'b1;
    else if (irq_ack & mode_iv)     flag_q <= 1'b0;
  end

  assign rd_data = {RD_KEY, ctrl};
  assign sys_rst = rst_q;
  assign flag    = flag_q;
  assign irq     = flag_q & mode_iv & irq_en & gie;

  AST_BAD_KEY_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[15:8] != WR_KEY) |=> (sys_rst && flag && rd_data[7:0] == 8'h00)); // R3
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[15:8] == WR_KEY) |=> (rd_data[7:0] == ($past(wr_data[7:0]) & ~CLR_MASK))); // R2
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> (cnt == '0 && rd_data[7:0] == 8'h00 && flag)); // R8
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl[B_HOLD] && !wr_en) |=> $stable(cnt)); // R7
  AST_OTHER_TICK_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl[B_SRC] && !slow_tick && !wr_en) |=> $stable(cnt)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (irq_ack && mode_iv && !wr_en && !tick) |=> !flag); // R11
  AST_NO_IRQ_IN_WDOG: assert property (@(posedge clk) disable iff (!por_n)
    (!mode_iv) |-> !irq); // R10

endmodule

// File: tb/tb_wdt_interval_timer.sv
module tb_wdt_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, por_n = 0, wr_en = 0, fast_tick = 0, slow_tick = 0;
  logic irq_en = 0, gie = 0, irq_ack = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic sys_rst, irq, flag;
  int checks = 0, failures = 0;
  bit done = 0;

  wdt_interval_timer dut (.clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .irq_en(irq_en), .gie(gie),
    .irq_ack(irq_ack), .rd_data(rd_data), .sys_rst(sys_rst), .irq(irq), .flag(flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_ctrl, m_cnt, m_flag, m_rst, m_n, m_mode, m_set;
  bit m_tick;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ctrl = 0; m_cnt = 0; m_flag = 0; m_rst = 0;
    end else begin
      m_mode = (m_ctrl >> 4) & 1;
      m_set = 0;
      m_rst = 0;
      if (wr_en) begin
        if (wr_data[15:8] != 8'h5A) begin
          m_rst = 1; m_ctrl = 0; m_cnt = 0; m_set = 1;
        end else begin
          m_ctrl = int'(wr_data[7:0]) & 'hF7;
          if (wr_data[3]) m_cnt = 0;
        end
      end else begin
        m_tick = ((m_ctrl >> 7) & 1) == 0 &&
                 ((((m_ctrl >> 2) & 1) == 1) ? slow_tick : fast_tick);
        if (m_tick) begin
          case (m_ctrl & 3)
            0: m_n = 15;
            1: m_n = 13;
            2: m_n = 9;
            default: m_n = 6;
          endcase
          m_cnt = (m_cnt + 1) % 65536;
          if (m_cnt % (1 << m_n) == 0) begin
            m_set = 1;
            if (m_mode == 0) begin m_rst = 1; m_ctrl = 0; m_cnt = 0; end
          end
        end
      end
      if (m_set) m_flag = 1;
      else if (irq_ack && m_mode == 1) m_flag = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && !done) begin
      chk("R2 model rd_data", int'(rd_data), 'h6900 | m_ctrl);
      chk("R8 model sys_rst", int'(sys_rst), m_rst);
      chk("R9 model flag", int'(flag), m_flag);
      chk("R10 model irq", int'(irq),
          (m_flag && ((m_ctrl >> 4) & 1) && irq_en && gie) ? 1 : 0);
    end
  end

  task automatic por();
    por_n = 0; wr_en = 0; fast_tick = 0; slow_tick = 0; irq_ack = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(int n, bit slow);
    if (slow) slow_tick = 1; else fast_tick = 1;
    repeat (n) @(negedge clk);
    fast_tick = 0; slow_tick = 0;
  endtask

  initial begin
    por();
    chk("R1 rd_data", rd_data, 'h6900);
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);

    // R1/R8: default watchdog fires after 2^15 fast ticks
    ticks(32767, 0);
    chk("R8 no early reset", sys_rst, 0);
    ticks(1, 0);
    chk("R8 reset pulse", sys_rst, 1);
    chk("R8 flag set", flag, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", sys_rst, 0);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R11 ack ignored in watchdog", flag, 1);

    // R2/R12
    por();
    wr(16'h5A7F);
    chk("R2 R12 readback", rd_data, 'h6977);
    chk("R2 no reset", sys_rst, 0);

    // R3
    wr(16'h1234);
    chk("R3 sys_rst", sys_rst, 1);
    chk("R3 flag", flag, 1);
    chk("R3 ctrl cleared", rd_data, 'h6900);
    @(negedge clk);
    chk("R3 single pulse", sys_rst, 0);

    // R4/R9/R10/R11: interval mode, 2^6
    por();
    wr(16'h5A1B);
    ticks(63, 0);
    chk("R4 r4_ no early flag", flag, 0);
    ticks(1, 0);
    chk("R9 flag at 2^6", flag, 1);
    chk("R9 no reset", sys_rst, 0);
    chk("R10 irq gated off", irq, 0);
    irq_en = 1; gie = 1; @(negedge clk);
    chk("R10 irq on", irq, 1);
    gie = 0; @(negedge clk);
    chk("R10 gie low", irq, 0);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R11 ack clears", flag, 0);
    ticks(63, 0);
    chk("R9 periodic not yet", flag, 0);
    irq_ack = 1; ticks(1, 0); irq_ack = 0;
    chk("R11 expiry beats ack", flag, 1);
    irq_en = 0;

    // R4: other taps
    por();
    wr(16'h5A1A);
    ticks(511, 0);
    chk("R4 2^9 early", flag, 0);
    ticks(1, 0);
    chk("R4 2^9 expiry", flag, 1);
    por();
    wr(16'h5A19);
    ticks(8191, 0);
    chk("R4 2^13 early", flag, 0);
    ticks(1, 0);
    chk("R4 2^13 expiry", flag, 1);

    // R5: slow source
    por();
    wr(16'h5A1F);
    ticks(100, 0);
    chk("R5 fast ignored", flag, 0);
    ticks(64, 1);
    chk("R5 slow counted", flag, 1);

    // R7: hold
    por();
    wr(16'h5A9B);
    ticks(200, 0);
    chk("R7 hold freezes", flag, 0);
    wr(16'h5A13);
    ticks(63, 0);
    chk("R7 resumed early", flag, 0);
    ticks(1, 0);
    chk("R7 resumed expiry", flag, 1);

    // R6: write without / with clear mid-count
    por();
    wr(16'h5A1B);
    ticks(40, 0);
    wr(16'h5A13);
    ticks(24, 0);
    chk("R6 count kept", flag, 1);
    por();
    wr(16'h5A1B);
    ticks(40, 0);
    wr(16'h5A1B);
    ticks(24, 0);
    chk("R6 clear restarts", flag, 0);
    ticks(40, 0);
    chk("R6 after restart", flag, 1);

    // R8: watchdog at 2^6
    por();
    wr(16'h5A0B);
    ticks(64, 0);
    chk("R8 wd 2^6 pulse", sys_rst, 1);
    chk("R8 wd ctrl cleared", rd_data, 'h6900);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired (R1) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule